// File: doc/BRIEF.md
# Flash Controller Interrupt and Status Unit

This block holds the interrupt, error and configuration state of a flash controller. A host reaches four 16-bit registers over a simple address/data bus: a command register, a system configuration register, a controller status register and an interrupt status register. The controller's command engine drives single-cycle pulses into the block. Completion pulses mark a finished load, program, erase or reset, or a generic event. Error pulses flag a failed command, erase, program or load.

The block drives one interrupt line whose polarity comes from a configuration bit. It also drives a ready line that software sets through the configuration register. A command write reaches the command engine only when no interrupt is pending. Software acknowledges events by writing an AND mask into the interrupt status register. When that write leaves the pending bit clear, the error flags are cleared as well.

The state has two reset sources. `rst_n` is an asynchronous cold reset. `warm_rst` is a synchronous warm-reset pulse from the command engine. The two leave different reset-done codes in the interrupt status register.

Top module: `flash_irq_regs`

## Requirements
- R1: After cold reset, configuration reads 0x40C0, interrupt status reads 0x8080, controller status reads 0x0000, the command register reads 0x0000, `ready` is 1 and `irq` is 1.
- R2: A completion pulse sets bit 15 of interrupt status together with its own done bit: reset-done is bit 4, erase-done is bit 5, program-done is bit 6 and load-done is bit 7. A generic pulse sets bit 15 only.
- R3: Error pulses set bits of the controller status register: command error is bit 10, erase error is bit 11, program error is bit 12 and load error is bit 13.
- R4: A bus write to interrupt status (address 3) replaces the register with the old value AND the written data.
- R5: When the masked value written in R4 has bit 15 clear, bits 10 to 13 of controller status are cleared. When bit 15 stays set, those bits are kept.
- R6: Completion and error pulses in the same cycle as an interrupt-status write are ORed in after the mask and the error clear are applied.
- R7: `irq` is bit 15 of interrupt status XOR the inverse of configuration bit 6. It is registered, so it changes one cycle after the register change that causes it.
- R8: A command write (address 0) made while bit 15 of interrupt status is set is ignored: the command register keeps its value and `cmd_go` stays low. Otherwise the command register takes the data and `cmd_go` pulses for one cycle in the next cycle.
- R9: A read of the configuration register (address 1) returns the stored value with bits 4 to 0 forced to zero.
- R10: A write to the configuration register sets `ready` to bit 7 of the written data.
- R11: A `warm_rst` pulse sets configuration to 0x40C0, interrupt status to 0x8010, controller status to 0x0000 and `ready` to 1, taking priority over bus writes and pulses in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous cold reset, active low |
| warm_rst | input | 1 | Synchronous warm reset pulse |
| reg_wr | input | 1 | Bus write strobe |
| reg_addr | input | 2 | Register select: 0 command, 1 configuration, 2 controller status, 3 interrupt status |
| reg_wdata | input | 16 | Bus write data |
| reg_rdata | output | 16 | Read data for the register at reg_addr |
| evt_load | input | 1 | Load completion pulse |
| evt_prog | input | 1 | Program completion pulse |
| evt_erase | input | 1 | Erase completion pulse |
| evt_reset | input | 1 | Reset completion pulse |
| evt_gen | input | 1 | Generic completion pulse |
| err_cmd | input | 1 | Command error pulse |
| err_erase | input | 1 | Erase error pulse |
| err_prog | input | 1 | Program error pulse |
| err_load | input | 1 | Load error pulse |
| irq | output | 1 | Interrupt line, polarity set by configuration bit 6 |
| ready | output | 1 | Ready line |
| cmd_go | output | 1 | One-cycle pulse for an accepted command |
| cmd_code | output | 16 | Last accepted command |

## Verification
The tests drive completion and error pulses alone and in groups, and each group shows up in a different bit. This separates the erase, program and load flags from one another and from the generic event. The tests write AND masks that keep bit 15 and masks that clear it, which shows whether the error wipe depends on the pending bit rather than on any write. They also write a mask in the same cycle as a pulse, to show that the new events survive the mask. Command writes are made once with an interrupt pending and once without, and the interrupt line is checked under both polarities.

// File: rtl/fir_pkg.sv
package fir_pkg;
   // interrupt status bit positions
   localparam int INT_RST  = 4;
   localparam int INT_ERS  = 5;
   localparam int INT_PRG  = 6;
   localparam int INT_LD   = 7;
   localparam int INT_PEND = 15;
   // controller status error positions
   localparam int ERR_CMD = 10;
   localparam int ERR_ERS = 11;
   localparam int ERR_PRG = 12;
   localparam int ERR_LD  = 13;
   // configuration bits
   localparam int CFG_POL = 6;
   localparam int CFG_RDY = 7;

   typedef struct packed {
      logic load;
      logic prog;
      logic erase;
      logic rst;
      logic gen;
   } fir_evt_t;

   typedef struct packed {
      logic cmd;
      logic erase;
      logic prog;
      logic load;
   } fir_err_t;
endpackage

// File: rtl/fir_int_status.sv
module fir_int_status
   import fir_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter logic [DATA_W-1:0] COLD_INTS = 16'h8080,
   parameter logic [DATA_W-1:0] WARM_INTS = 16'h8010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              warm,
   input  logic              wr_ints,
   input  logic [DATA_W-1:0] wdata,
   input  fir_evt_t          evt,
   input  fir_err_t          err,
   output logic [DATA_W-1:0] ints,
   output logic [DATA_W-1:0] stat
);
   localparam logic [DATA_W-1:0] ERR_MASK =
      DATA_W'((1 << ERR_CMD) | (1 << ERR_ERS) | (1 << ERR_PRG) | (1 << ERR_LD));

   logic [DATA_W-1:0] masked, set_bits, err_bits, ints_n, stat_n;
   logic              wipe;

   always_comb begin
      masked   = wr_ints ? (ints & wdata) : ints;
      set_bits = '0;
      set_bits[INT_LD]   = evt.load;
      set_bits[INT_PRG]  = evt.prog;
      set_bits[INT_ERS]  = evt.erase;
      set_bits[INT_RST]  = evt.rst;
      set_bits[INT_PEND] = |evt;
      err_bits = '0;
      err_bits[ERR_CMD] = err.cmd;
      err_bits[ERR_ERS] = err.erase;
      err_bits[ERR_PRG] = err.prog;
      err_bits[ERR_LD]  = err.load;
      wipe   = wr_ints & ~masked[INT_PEND];
      ints_n = masked | set_bits;
      stat_n = (wipe ? (stat & ~ERR_MASK) : stat) | err_bits;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ints <= COLD_INTS;
         stat <= '0;
      end else if (warm) begin
         ints <= WARM_INTS;
         stat <= '0;
      end else begin
         ints <= ints_n;
         stat <= stat_n;
      end
   end

   assert_load_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.load && !warm) |=> (ints[INT_LD] && ints[INT_PEND]));

   assert_err_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (err.prog && !warm) |=> stat[ERR_PRG]);

   assert_err_wipe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ints && !wdata[INT_PEND] && err == '0 && !warm) |=> (stat[ERR_LD:ERR_CMD] == '0));

   assert_warm_values_R11: assert property (@(posedge clk) disable iff (!rst_n)
      warm |=> (ints == WARM_INTS && stat == '0));
endmodule

// File: rtl/fir_cfg_reg.sv
module fir_cfg_reg
   import fir_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter logic [DATA_W-1:0] RST_CFG = 16'h40C0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              warm,
   input  logic              wr_cfg,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] cfg,
   output logic              ready
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg   <= RST_CFG;
         ready <= 1'b1;
      end else if (warm) begin
         cfg   <= RST_CFG;
         ready <= 1'b1;
      end else if (wr_cfg) begin
         cfg   <= wdata;
         ready <= wdata[CFG_RDY];
      end
   end

   assert_ready_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cfg && !warm) |=> (ready == $past(wdata[CFG_RDY])));
endmodule

// File: rtl/fir_irq_out.sv
module fir_irq_out #(
   parameter bit IRQ_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pend,
   input  logic pol,
   output logic irq
);
   logic level;
   assign level = pend ^ ~pol;

   generate
      if (IRQ_REG) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b1;
            else        irq_q <= level;
         end
         assign irq = irq_q;

         assert_irq_lag_R7: assert property (@(posedge clk) disable iff (!rst_n)
            irq == $past(pend ^ ~pol));
      end else begin : g_comb
         assign irq = level;
      end
   endgenerate
endmodule

// File: rtl/fir_cmd_gate.sv
module fir_cmd_gate #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              warm,
   input  logic              wr_cmd,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pend,
   output logic [DATA_W-1:0] cmd,
   output logic              go
);
   logic take;
   assign take = wr_cmd & ~pend & ~warm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd <= '0;
         go  <= 1'b0;
      end else begin
         go <= take;
         if (warm)      cmd <= '0;
         else if (take) cmd <= wdata;
      end
   end

   assert_cmd_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd && pend) |=> (!go && $stable(cmd)));
endmodule

// File: rtl/flash_irq_regs.sv
module flash_irq_regs
   import fir_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 2,
   parameter bit IRQ_REG = 1'b1,
   parameter logic [ADDR_W-1:0] A_CMD  = 2'd0,
   parameter logic [ADDR_W-1:0] A_CFG  = 2'd1,
   parameter logic [ADDR_W-1:0] A_STAT = 2'd2,
   parameter logic [ADDR_W-1:0] A_INTS = 2'd3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              warm_rst,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              evt_load,
   input  logic              evt_prog,
   input  logic              evt_erase,
   input  logic              evt_reset,
   input  logic              evt_gen,
   input  logic              err_cmd,
   input  logic              err_erase,
   input  logic              err_prog,
   input  logic              err_load,
   output logic              irq,
   output logic              ready,
   output logic              cmd_go,
   output logic [DATA_W-1:0] cmd_code
);
   localparam logic [DATA_W-1:0] CFG_RD_MASK = ~DATA_W'(5'h1F);

   generate
      if (DATA_W != 16) begin : g_bad_width
         $error("flash_irq_regs: DATA_W must be 16");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("flash_irq_regs: ADDR_W must be at least 2");
      end
   endgenerate

   fir_evt_t          evt;
   fir_err_t          err;
   logic [DATA_W-1:0] ints, stat, cfg;
   logic              wr_cmd, wr_cfg, wr_ints;

   assign evt = '{load: evt_load, prog: evt_prog, erase: evt_erase, rst: evt_reset, gen: evt_gen};
   assign err = '{cmd: err_cmd, erase: err_erase, prog: err_prog, load: err_load};

   assign wr_cmd  = reg_wr && (reg_addr == A_CMD);
   assign wr_cfg  = reg_wr && (reg_addr == A_CFG);
   assign wr_ints = reg_wr && (reg_addr == A_INTS);

   fir_int_status #(.DATA_W(DATA_W)) u_ints (
      .clk(clk), .rst_n(rst_n), .warm(warm_rst), .wr_ints(wr_ints),
      .wdata(reg_wdata), .evt(evt), .err(err), .ints(ints), .stat(stat));

   fir_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .warm(warm_rst), .wr_cfg(wr_cfg),
      .wdata(reg_wdata), .cfg(cfg), .ready(ready));

   fir_irq_out #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk(clk), .rst_n(rst_n), .pend(ints[INT_PEND]), .pol(cfg[CFG_POL]), .irq(irq));

   fir_cmd_gate #(.DATA_W(DATA_W)) u_cmd (
      .clk(clk), .rst_n(rst_n), .warm(warm_rst), .wr_cmd(wr_cmd),
      .wdata(reg_wdata), .pend(ints[INT_PEND]), .cmd(cmd_code), .go(cmd_go));

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == A_CMD)       reg_rdata = cmd_code;
      else if (reg_addr == A_CFG)  reg_rdata = cfg & CFG_RD_MASK;
      else if (reg_addr == A_STAT) reg_rdata = stat;
      else if (reg_addr == A_INTS) reg_rdata = ints;
   end
endmodule

// File: tb/sim_flash_irq_regs.sv
module sim_flash_irq_regs;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic warm_rst = 1'b0;
   logic reg_wr = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic evt_load = 0, evt_prog = 0, evt_erase = 0, evt_reset = 0, evt_gen = 0;
   logic err_cmd = 0, err_erase = 0, err_prog = 0, err_load = 0;
   logic irq, ready, cmd_go;
   logic [15:0] cmd_code;
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   flash_irq_regs u0 (
      .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .evt_load(evt_load), .evt_prog(evt_prog), .evt_erase(evt_erase),
      .evt_reset(evt_reset), .evt_gen(evt_gen), .err_cmd(err_cmd),
      .err_erase(err_erase), .err_prog(err_prog), .err_load(err_load),
      .irq(irq), .ready(ready), .cmd_go(cmd_go), .cmd_code(cmd_code));

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic rd(input string req, input logic [1:0] a, input logic [15:0] exp);
      reg_addr = a;
      #0.5;
      chk(req, reg_rdata, exp);
   endtask

   // one bus write, returns at the negedge after the latching edge
   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   task automatic t_reset();
      rd("R1 cfg", 2'd1, 16'h40C0);
      rd("R1 ints", 2'd3, 16'h8080);
      rd("R1 stat", 2'd2, 16'h0000);
      rd("R1 cmd", 2'd0, 16'h0000);
      chk("R1 ready", 16'(ready), 16'd1);
      chk("R1 irq", 16'(irq), 16'd1);
   endtask

   task automatic t_cmd_blocked();
      wr(2'd0, 16'h0094);
      chk("R8 no go", 16'(cmd_go), 16'd0);
      rd("R8 cmd kept", 2'd0, 16'h0000);
   endtask

   task automatic t_clear_all();
      wr(2'd3, 16'h0000);
      rd("R4 ints cleared", 2'd3, 16'h0000);
      chk("R7 irq lags", 16'(irq), 16'd1);
      idle();
      chk("R7 irq low", 16'(irq), 16'd0);
   endtask

   task automatic t_cmd_accept();
      wr(2'd0, 16'h0094);
      chk("R8 go", 16'(cmd_go), 16'd1);
      rd("R8 cmd taken", 2'd0, 16'h0094);
      idle();
      chk("R8 go one cycle", 16'(cmd_go), 16'd0);
   endtask

   task automatic t_erase_err();
      evt_erase = 1; err_erase = 1;
      idle();
      evt_erase = 0; err_erase = 0;
      rd("R2 erase done", 2'd3, 16'h8020);
      rd("R3 erase err", 2'd2, 16'h0800);
      idle();
      chk("R7 irq high", 16'(irq), 16'd1);
   endtask

   task automatic t_mask_keep();
      wr(2'd3, 16'h8000);
      rd("R4 mask", 2'd3, 16'h8000);
      rd("R5 err kept", 2'd2, 16'h0800);
      wr(2'd3, 16'h7FFF);
      rd("R4 pend gone", 2'd3, 16'h0000);
      rd("R5 err wiped", 2'd2, 16'h0000);
   endtask

   task automatic t_events();
      evt_gen = 1; idle(); evt_gen = 0;
      rd("R2 generic", 2'd3, 16'h8000);
      wr(2'd3, 16'h0000);
      evt_load = 1; evt_reset = 1; err_load = 1; err_cmd = 1;
      idle();
      evt_load = 0; evt_reset = 0; err_load = 0; err_cmd = 0;
      rd("R2 load+reset", 2'd3, 16'h8090);
      rd("R3 load+cmd err", 2'd2, 16'h2400);
   endtask

   task automatic t_same_cycle();
      // pending is set; clear-all write meets a program pulse and error
      reg_wr = 1; reg_addr = 2'd3; reg_wdata = 16'h0000;
      evt_prog = 1; err_prog = 1;
      idle();
      reg_wr = 0; evt_prog = 0; err_prog = 0;
      rd("R6 event kept", 2'd3, 16'h8040);
      rd("R6 err after wipe", 2'd2, 16'h1000);
      wr(2'd3, 16'h0000);
      rd("R5 wipe", 2'd2, 16'h0000);
   endtask

   task automatic t_polarity();
      idle();
      chk("R7 base", 16'(irq), 16'd0);
      wr(2'd1, 16'h009F);
      rd("R9 cfg mask", 2'd1, 16'h0080);
      chk("R10 ready set", 16'(ready), 16'd1);
      idle();
      chk("R7 inverted", 16'(irq), 16'd1);
      wr(2'd1, 16'h0000);
      chk("R10 ready clr", 16'(ready), 16'd0);
      evt_gen = 1; idle(); evt_gen = 0;
      idle();
      chk("R7 pend inverted", 16'(irq), 16'd0);
   endtask

   task automatic t_warm();
      err_cmd = 1;
      warm_rst = 1;
      idle();
      warm_rst = 0; err_cmd = 0;
      rd("R11 cfg", 2'd1, 16'h40C0);
      rd("R11 ints", 2'd3, 16'h8010);
      rd("R11 stat", 2'd2, 16'h0000);
      chk("R11 ready", 16'(ready), 16'd1);
   endtask

   initial begin
      #1000000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      idle();
      t_reset();
      t_cmd_blocked();
      t_clear_all();
      t_cmd_accept();
      t_erase_err();
      t_mask_keep();
      t_events();
      t_same_cycle();
      t_polarity();
      t_warm();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule